// File: doc/BRIEF.md
# PWM Output Forced-Shutdown Controller

This block holds a small 8-bit control register and a sticky cutoff latch. Once the latch is set, a vector of PWM pulse outputs is driven to a safe, parameterised idle pattern. Three sources can set the latch:

- an active-low external trip pin, when its enable bit is set;
- a one-cycle pulse from an event-link fabric;
- a software write of 1 to the flag bit.

Hardware never clears the latch. Software clears it by writing 0 to the flag, and that write only takes effect while the associated timer reports that it is stopped.

The register sits on a simple synchronous bus: address, write enable, write data, and a registered read data port. The PWM generator feeds its raw outputs into `pwm_i` and takes the gated copy from `pwm_o`. The trip pin passes through a two-flop synchronizer before its level is examined.

Top module: `pwm_cutoff_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the register holds 0x00, `cut_o` is 0, `pwm_o` equals `IDLE_LVL` and `bus_rdata_o` is 0.
- R2: At address `REG_ADDR`, bit 7 is the trip-pin enable and bit 0 is the cutoff flag. Bits 6..1 always read 0, and any value written to them is ignored. Writes to any other address change nothing, and reads of any other address return 0.
- R3: Read data appears on `bus_rdata_o` one clock edge after the address is presented. It shows the register contents as they were before that edge.
- R4: With the enable bit at 1, a low level on `trip_n_i` sets the flag on the third rising edge after the level first appears, because the pin is synchronised through two stages.
- R5: With the enable bit at 0, a low level on `trip_n_i` leaves the flag unchanged.
- R6: A one-cycle pulse on `evt_i` sets the flag on the next edge.
- R7: The flag is sticky and `cut_o` mirrors it. Only a software write of 0 clears it, and only when `tmr_run_i` is 0. With `tmr_run_i` at 1, a write of 0 leaves the flag at 1.
- R8: A software write of 1 to the flag sets it on the next edge, whatever the timer state.
- R9: If a hardware set condition (pin or event) and a software clear fall in the same cycle, the flag ends up at 1.
- R10: `pwm_o` is registered. On each edge it loads `IDLE_LVL` if the flag was 1 before the edge, and otherwise loads `pwm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_n_i | input | 1 | External shutdown pin, active low, asynchronous |
| evt_i | input | 1 | Single-cycle shutdown event from the event fabric |
| tmr_run_i | input | 1 | Timer running status (1 = counting) |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_we_i | input | 1 | Register bus write enable |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Registered read data |
| pwm_i | input | NUM_OUT | Raw PWM outputs from the generator |
| pwm_o | output | NUM_OUT | Gated PWM outputs |
| cut_o | output | 1 | Sticky cutoff flag |

## Verification
The bench sweeps every combination of prior flag state, timer state, event pulse and written flag bit, and compares the result against the arithmetic form flag = event OR written-one OR (old flag AND running). A design that let a running timer accept a clear, or that gave the clear priority over a simultaneous event, would show a 0 where 1 is expected.

The bench measures pin-to-flag latency at exactly three edges, and it drives the pin low with the enable cleared. A missing synchronizer stage, or a pin path that ignored its enable, would show up in either case.

All sixteen PWM input patterns are checked both passed through and forced idle. Reserved bits and writes to other addresses are read back to catch decode or masking faults.

// File: rtl/pwm_cutoff_pkg.sv
package pwm_cutoff_pkg;

    localparam int REG_W   = 8;
    localparam int EN_BIT  = 7;
    localparam int CUT_BIT = 0;

    typedef struct packed {
        logic             pin_en;
        logic             cut;
        logic [REG_W-1:0] rdata;
    } cut_regs_t;

    function automatic logic [REG_W-1:0] pack_reg(input logic en, input logic cut);
        logic [REG_W-1:0] v;
        v          = '0;
        v[EN_BIT]  = en;
        v[CUT_BIT] = cut;
        return v;
    endfunction

endpackage

// File: rtl/pwm_cutoff_sync.sv
module pwm_cutoff_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_cutoff_regs.sv
module pwm_cutoff_regs
    import pwm_cutoff_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_lvl_i,
    input  logic             evt_i,
    input  logic             tmr_run_i,
    input  logic             hit_we_i,
    input  logic             hit_rd_i,
    input  logic             wr_en_i,
    input  logic             wr_cut_i,
    output logic             cut_o,
    output logic [REG_W-1:0] rdata_o
);

    cut_regs_t r_d, r_q;
    logic      hw_set;
    logic      sw_set;
    logic      sw_clr;

    always_comb begin
        hw_set = (r_q.pin_en && !pin_lvl_i) || evt_i;
        sw_set = hit_we_i && wr_cut_i;
        sw_clr = hit_we_i && !wr_cut_i && !tmr_run_i;

        r_d = r_q;
        if (hit_we_i) r_d.pin_en = wr_en_i;

        if (hw_set || sw_set) r_d.cut = 1'b1;
        else if (sw_clr)      r_d.cut = 1'b0;

        r_d.rdata = hit_rd_i ? pack_reg(r_q.pin_en, r_q.cut) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cut_o   = r_q.cut;
    assign rdata_o = r_q.rdata;

endmodule

// File: rtl/pwm_cutoff_gate.sv
module pwm_cutoff_gate #(
    parameter int                 NUM_OUT  = 4,
    parameter logic [NUM_OUT-1:0] IDLE_LVL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cut_i,
    input  logic [NUM_OUT-1:0] pwm_i,
    output logic [NUM_OUT-1:0] pwm_o
);

    logic [NUM_OUT-1:0] out_d, out_q;

    always_comb begin
        for (int i = 0; i < NUM_OUT; i++) begin
            out_d[i] = cut_i ? IDLE_LVL[i] : pwm_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= IDLE_LVL;
        else        out_q <= out_d;
    end

    assign pwm_o = out_q;

endmodule

// File: rtl/pwm_cutoff_ctrl.sv
module pwm_cutoff_ctrl
    import pwm_cutoff_pkg::*;
#(
    parameter int                 NUM_OUT     = 4,
    parameter int                 ADDR_W      = 4,
    parameter logic [ADDR_W-1:0]  REG_ADDR    = '0,
    parameter logic [NUM_OUT-1:0] IDLE_LVL    = '0,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trip_n_i,
    input  logic               evt_i,
    input  logic               tmr_run_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    input  logic [NUM_OUT-1:0] pwm_i,
    output logic [NUM_OUT-1:0] pwm_o,
    output logic               cut_o
);

    logic trip_sync;
    logic addr_hit;
    logic hit_we;

    assign addr_hit = (bus_addr_i == REG_ADDR);
    assign hit_we   = addr_hit && bus_we_i;

    pwm_cutoff_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trip_n_i),
        .sync_o  (trip_sync)
    );

    pwm_cutoff_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl_i (trip_sync),
        .evt_i     (evt_i),
        .tmr_run_i (tmr_run_i),
        .hit_we_i  (hit_we),
        .hit_rd_i  (addr_hit),
        .wr_en_i   (bus_wdata_i[EN_BIT]),
        .wr_cut_i  (bus_wdata_i[CUT_BIT]),
        .cut_o     (cut_o),
        .rdata_o   (bus_rdata_o)
    );

    pwm_cutoff_gate #(
        .NUM_OUT  (NUM_OUT),
        .IDLE_LVL (IDLE_LVL)
    ) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .cut_i (cut_o),
        .pwm_i (pwm_i),
        .pwm_o (pwm_o)
    );

endmodule

// File: rtl/pwm_cutoff_chk.sv
module pwm_cutoff_chk #(
    parameter int                 NUM_OUT  = 4,
    parameter int                 ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]  REG_ADDR = '0,
    parameter logic [NUM_OUT-1:0] IDLE_LVL = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               evt_i,
    input logic               tmr_run_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_we_i,
    input logic [7:0]         bus_wdata_i,
    input logic [7:0]         bus_rdata_o,
    input logic [NUM_OUT-1:0] pwm_i,
    input logic [NUM_OUT-1:0] pwm_o,
    input logic               cut_o
);

    logic reg_write;
    assign reg_write = bus_we_i && (bus_addr_i == REG_ADDR);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[6:1] == 6'd0);

    // R2
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i != REG_ADDR) |=> (bus_rdata_o == 8'd0));

    // R6
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> cut_o);

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_o && tmr_run_i) |=> cut_o);

    // R7
    no_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_o && !reg_write) |=> cut_o);

    // R8
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_write && bus_wdata_i[0]) |=> cut_o);

    // R10
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_o |=> (pwm_o == IDLE_LVL));

    // R10
    gate_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cut_o |=> (pwm_o == $past(pwm_i)));

endmodule

bind pwm_cutoff_ctrl pwm_cutoff_chk #(
    .NUM_OUT  (NUM_OUT),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .IDLE_LVL (IDLE_LVL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .tmr_run_i   (tmr_run_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pwm_i       (pwm_i),
    .pwm_o       (pwm_o),
    .cut_o       (cut_o)
);

// File: tb/sim_pwm_cutoff_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_cutoff_ctrl;

    localparam int          NO   = 4;
    localparam int          AW   = 4;
    localparam logic [3:0]  RA   = 4'h9;
    localparam logic [3:0]  OA   = 4'h3;
    localparam logic [3:0]  IDLE = 4'b0110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_n = 1'b1;
    logic          evt = 1'b0;
    logic          tmr = 1'b0;
    logic [AW-1:0] addr = OA;
    logic          we = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [NO-1:0] pwm_in = '0;
    logic [NO-1:0] pwm_out;
    logic          cut;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwm_cutoff_ctrl #(
        .NUM_OUT (NO), .ADDR_W (AW), .REG_ADDR (RA), .IDLE_LVL (IDLE)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .trip_n_i (trip_n), .evt_i (evt),
        .tmr_run_i (tmr), .bus_addr_i (addr), .bus_we_i (we),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .pwm_i (pwm_in),
        .pwm_o (pwm_out), .cut_o (cut)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = OA;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        v = rdata;
        addr = OA;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 cut", {7'd0, cut}, 8'h00);
        check("R1 pwm", {4'd0, pwm_out}, {4'd0, IDLE});
        check("R1 rdata", rdata, 8'h00);
        rst_n = 1'b1;
        rd(RA, v);
        check("R1 reg", v, 8'h00);

        // R10: pass-through sweep with flag clear
        for (int p = 0; p < 16; p++) begin
            @(negedge clk); pwm_in = p[3:0];
            @(negedge clk);
            check("R10 pass", {4'd0, pwm_out}, {4'd0, p[3:0]});
        end

        // R2: reserved bits masked; R3 read latency
        wr(RA, 8'hFE);
        rd(RA, v);
        check("R2 rsvd", v, 8'h80);
        wr(OA, 8'h01);
        check("R2 other addr write", {7'd0, cut}, 8'h00);
        rd(OA, v);
        check("R2 other addr read", v, 8'h00);
        // R3: same-cycle write is not visible, next read is
        @(negedge clk); we = 1'b1; addr = RA; wdata = 8'h00;
        @(negedge clk); we = 1'b0;
        check("R3 old value", rdata, 8'h80);
        @(negedge clk);
        check("R3 new value", rdata, 8'h00);

        // R5: pin ignored when disabled
        @(negedge clk); trip_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 pin disabled", {7'd0, cut}, 8'h00);
        trip_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: pin enabled, three-edge latency
        wr(RA, 8'h80);
        @(negedge clk); trip_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 before sync", {7'd0, cut}, 8'h00);
        @(negedge clk);
        check("R4 after sync", {7'd0, cut}, 8'h01);
        trip_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: forced idle sweep
        for (int p = 0; p < 16; p++) begin
            @(negedge clk); pwm_in = p[3:0];
            @(negedge clk);
            check("R10 idle", {4'd0, pwm_out}, {4'd0, IDLE});
        end

        // R7: clear blocked while running
        tmr = 1'b1;
        wr(RA, 8'h80);
        check("R7 run hold", {7'd0, cut}, 8'h01);
        rd(RA, v);
        check("R7 readback", v, 8'h81);
        tmr = 1'b0;
        wr(RA, 8'h00);
        check("R7 stopped clear", {7'd0, cut}, 8'h00);

        // R6: event pulse
        @(negedge clk); evt = 1'b1;
        @(negedge clk); evt = 1'b0;
        check("R6 event", {7'd0, cut}, 8'h01);
        wr(RA, 8'h00);

        // R8: software set while running
        tmr = 1'b1;
        wr(RA, 8'h01);
        check("R8 sw set", {7'd0, cut}, 8'h01);
        rd(RA, v);
        check("R8 readback", v, 8'h01);
        tmr = 1'b0;

        // R9 / R7 / R8: exhaustive flag update sweep
        for (int c = 0; c < 16; c++) begin
            logic init, t, e, b, exp;
            init = c[3]; t = c[2]; e = c[1]; b = c[0];
            wr(RA, {7'd0, init});
            @(negedge clk);
            tmr = t; evt = e; we = 1'b1; addr = RA; wdata = {7'd0, b};
            @(negedge clk);
            we = 1'b0; evt = 1'b0; tmr = 1'b0; addr = OA;
            exp = e | b | (init & t);
            check("R9 sweep", {4'd0, init, t, e, cut}, {4'd0, init, t, e, exp});
        end

        finish_run();
    end

endmodule